// File: doc/BRIEF.md
# Platform Power-Up Sequencer

This block is the supply-and-reset controller of a board. Pressing the power button starts the bring-up. The block switches on four supply rails one after another, through external transistor switches. It moves to the next rail only after the power-good of the current rail has been seen. Once every rail is good, it waits for the platform clock generator to report lock. The lock and all power-goods must then hold for a fixed settling window, and only after that does the block deassert the processor's active-low reset.

A rail that fails to report power-good within its own cycle budget sends the block into a latched fault. Any of the following while powered starts an orderly shutdown: releasing the button, losing any power-good, or losing clock lock once running. In a shutdown or a fault, reset is asserted first. The rails are then switched off in the reverse of their switch-on order, one at a time. The button, the power-goods and the lock input are treated as asynchronous and pass through a two-stage synchronizer before use. Rail numbering is 0 = 1.5 V, 1 = 3.3 V, 2 = 5 V, 3 = 12 V. The switch-on order is a parameter array of rail numbers and defaults to 3, 2, 1, 0.

Top module: `pwr_seq_top`

## Requirements
- R1: Rail enables rise one at a time in the order given by RAIL_ORDER (default rail 3, 2, 1, then 0). The rail at step k+1 is enabled only after the rail at step k reports power-good.
- R2: If the newest enabled rail has not reported power-good within RAIL_TIMEOUT[rail] cycles of its enable rising, the block latches a fault. It switches all enabled rails off in reverse order, and processor reset stays asserted throughout.
- R3: Processor reset is deasserted only when all enables are high, all power-goods are high and lock is high. These conditions must have held for at least STAB_CYCLES consecutive cycles. Without lock, reset is never released.
- R4: A shutdown starts on button release, on loss of any power-good that is already required, or on loss of lock while running. Processor reset is asserted first, and the first rail is dropped no earlier than OFF_GAP cycles later.
- R5: During a shutdown or fault, rails are switched off in exactly the reverse of their switch-on order, one rail every OFF_GAP cycles, until none remain on.
- R6: A bring-up starts only on a new press, meaning a low-to-high change of the synchronized button. A button that is still held after a shutdown or a fault does not restart the rails.
- R7: After reset, all rail enables are low and processor reset is asserted (low).
- R8: At most one rail enable changes in any clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| pwr_btn_i | input | 1 | Power button, high while pressed (asynchronous) |
| rail_pg_i | input | N_RAILS | Power-good per rail, bit index = rail number (asynchronous) |
| pll_lock_i | input | 1 | Platform clock lock indication (asynchronous) |
| rail_en_o | output | N_RAILS | Registered switch enable per rail, bit index = rail number |
| cpu_rst_n_o | output | 1 | Registered active-low processor reset |

## Verification
A wrong step counter or a wrong state shows at the enable pins within one cycle. It appears as a rail out of order, two enables moving together, or a rail dropped while reset is still released. A timer that runs too long or too short moves either the fault shutdown or the reset release outside a window of a few cycles around RAIL_TIMEOUT or STAB_CYCLES. A failure to latch the fault or the shutdown shows as rails coming back within tens of cycles while the button is held.

// File: rtl/pwr_seq_pkg.sv
// Package: shared types of the power-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pwr_seq_pkg;

    // Sequencer states; encoding is private to the block.
    typedef enum logic [2:0] {
        SEQ_OFF   = 3'd0,
        SEQ_RAMP  = 3'd1,
        SEQ_LOCK  = 3'd2,
        SEQ_STAB  = 3'd3,
        SEQ_RUN   = 3'd4,
        SEQ_DOWN  = 3'd5,
        SEQ_FAULT = 3'd6
    } seq_state_e;

endpackage

// File: rtl/pwr_seq_sync.sv
// Module: multi-stage synchronizer for a bus of independent asynchronous
// level signals. Each bit is synchronized on its own, with no coherency
// between bits.
// Assumes: inputs are slow levels; reset value of every stage is 0.
module pwr_seq_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d_i;
            end
        end else begin : g_next
            // Later flops settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pwr_seq_timer.sv
// Module: shared cycle counter for the sequencer. The counter is cleared
// on request and otherwise advances while enabled.
// Assumes: the controller never lets it wrap (limits fit TMR_W).
module pwr_seq_timer #(
    parameter int unsigned TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [TMR_W-1:0] cnt_o
);

    // Clear has priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_o <= '0;
        else if (inc_i)      cnt_o <= cnt_o + TMR_W'(1);
    end

endmodule

// File: rtl/pwr_seq_map.sv
// Module: turns a step level (number of rails on, counted in switch-on
// order) into a per-rail enable vector indexed by rail number.
// Assumes: RAIL_ORDER is a permutation of 0..N_RAILS-1.
module pwr_seq_map #(
    parameter int unsigned N_RAILS              = 4,
    parameter int unsigned RAIL_ORDER [N_RAILS] = '{3, 2, 1, 0},
    parameter int unsigned LVL_W                = 3
) (
    input  logic [LVL_W-1:0]   lvl_i,
    output logic [N_RAILS-1:0] en_o
);

    // Step k is on whenever the level exceeds k.
    always_comb begin
        en_o = '0;
        for (int k = 0; k < N_RAILS; k++) begin
            if (lvl_i > LVL_W'(k)) en_o[RAIL_ORDER[k]] = 1'b1;
        end
    end

endmodule

// File: rtl/pwr_seq_sel.sv
// Module: for the current level, names the newest rail (the one being
// brought up) and the terminal count of its power-good timeout.
// Assumes: level 0 selects nothing; outputs are then don't-care.
module pwr_seq_sel #(
    parameter int unsigned N_RAILS                = 4,
    parameter int unsigned RAIL_ORDER   [N_RAILS] = '{3, 2, 1, 0},
    parameter int unsigned RAIL_TIMEOUT [N_RAILS] = '{2000, 2000, 2000, 2000},
    parameter int unsigned LVL_W                  = 3,
    parameter int unsigned IDX_W                  = 2,
    parameter int unsigned TMR_W                  = 16
) (
    input  logic [LVL_W-1:0] lvl_i,
    output logic [IDX_W-1:0] cur_rail_o,
    output logic [TMR_W-1:0] cur_last_o
);

    // Look up the rail at step lvl-1 and its last allowed wait cycle.
    always_comb begin
        cur_rail_o = '0;
        cur_last_o = '0;
        for (int k = 0; k < N_RAILS; k++) begin
            if (lvl_i == LVL_W'(k + 1)) begin
                cur_rail_o = IDX_W'(RAIL_ORDER[k]);
                cur_last_o = TMR_W'(RAIL_TIMEOUT[RAIL_ORDER[k]] - 1);
            end
        end
    end

endmodule

// File: rtl/pwr_seq_fsm.sv
// Module: sequencing controller. It holds the state and the step level
// (rails on), drives the shared timer and produces the next level and the
// registered processor reset.
// Assumes: all status inputs are already synchronized; the timer clears
// on tmr_clr_o and counts on tmr_inc_o.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int unsigned N_RAILS     = 4,
    parameter int unsigned STAB_CYCLES = 1000,
    parameter int unsigned OFF_GAP     = 50,
    parameter int unsigned LVL_W       = 3,
    parameter int unsigned IDX_W       = 2,
    parameter int unsigned TMR_W       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               btn_i,
    input  logic [N_RAILS-1:0] pg_i,
    input  logic               lock_i,
    input  logic [N_RAILS-1:0] en_now_i,
    input  logic [IDX_W-1:0]   cur_rail_i,
    input  logic [TMR_W-1:0]   cur_last_i,
    input  logic [TMR_W-1:0]   tmr_i,
    output logic               tmr_clr_o,
    output logic               tmr_inc_o,
    output logic [LVL_W-1:0]   lvl_q_o,
    output logic [LVL_W-1:0]   lvl_d_o,
    output logic               cpu_rst_n_o
);

    localparam logic [TMR_W-1:0] STAB_LAST = TMR_W'(STAB_CYCLES - 1);
    localparam logic [TMR_W-1:0] GAP_LAST  = TMR_W'(OFF_GAP - 1);
    localparam logic [LVL_W-1:0] LVL_FULL  = LVL_W'(N_RAILS);

    seq_state_e         state_q, state_d;
    logic [LVL_W-1:0]   lvl_q, lvl_d;
    logic               btn_prev_q;
    logic               btn_rise;
    logic [N_RAILS-1:0] req_mask;
    logic               req_lost;
    logic               all_good;

    assign btn_rise = btn_i && !btn_prev_q;
    assign all_good = &pg_i;

    // Rails already confirmed: every enabled rail except the newest one.
    always_comb begin
        req_mask = en_now_i;
        req_mask[cur_rail_i] = 1'b0;
    end
    assign req_lost = |(req_mask & ~pg_i);

    // Next-state, level and timer control.
    always_comb begin
        state_d   = state_q;
        lvl_d     = lvl_q;
        tmr_clr_o = 1'b0;
        tmr_inc_o = 1'b0;
        unique case (state_q)
            SEQ_OFF: begin
                if (btn_rise) begin
                    state_d   = SEQ_RAMP;
                    lvl_d     = LVL_W'(1);
                    tmr_clr_o = 1'b1;
                end
            end
            SEQ_RAMP: begin
                if (!btn_i || req_lost) begin
                    state_d   = SEQ_DOWN;
                    tmr_clr_o = 1'b1;
                end else if (pg_i[cur_rail_i]) begin
                    tmr_clr_o = 1'b1;
                    if (lvl_q == LVL_FULL) state_d = SEQ_LOCK;
                    else                   lvl_d   = lvl_q + LVL_W'(1);
                end else if (tmr_i == cur_last_i) begin
                    state_d   = SEQ_FAULT;
                    tmr_clr_o = 1'b1;
                end else begin
                    tmr_inc_o = 1'b1;
                end
            end
            SEQ_LOCK: begin
                if (!btn_i || !all_good) begin
                    state_d   = SEQ_DOWN;
                    tmr_clr_o = 1'b1;
                end else if (lock_i) begin
                    state_d   = SEQ_STAB;
                    tmr_clr_o = 1'b1;
                end
            end
            SEQ_STAB: begin
                if (!btn_i || !all_good) begin
                    state_d   = SEQ_DOWN;
                    tmr_clr_o = 1'b1;
                end else if (!lock_i) begin
                    state_d   = SEQ_LOCK;
                    tmr_clr_o = 1'b1;
                end else if (tmr_i == STAB_LAST) begin
                    state_d   = SEQ_RUN;
                end else begin
                    tmr_inc_o = 1'b1;
                end
            end
            SEQ_RUN: begin
                if (!btn_i || !all_good || !lock_i) begin
                    state_d   = SEQ_DOWN;
                    tmr_clr_o = 1'b1;
                end
            end
            SEQ_DOWN, SEQ_FAULT: begin
                if (lvl_q != '0) begin
                    if (tmr_i == GAP_LAST) begin
                        lvl_d     = lvl_q - LVL_W'(1);
                        tmr_clr_o = 1'b1;
                    end else begin
                        tmr_inc_o = 1'b1;
                    end
                end else if (state_q == SEQ_DOWN || !btn_i) begin
                    state_d = SEQ_OFF;
                end
            end
            default: begin
                state_d = SEQ_OFF;
                lvl_d   = '0;
            end
        endcase
    end

    // State, level, button history and processor reset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_OFF;
            lvl_q       <= '0;
            btn_prev_q  <= 1'b0;
            cpu_rst_n_o <= 1'b0;
        end else begin
            state_q     <= state_d;
            lvl_q       <= lvl_d;
            btn_prev_q  <= btn_i;
            cpu_rst_n_o <= (state_d == SEQ_RUN);
        end
    end

    assign lvl_q_o = lvl_q;
    assign lvl_d_o = lvl_d;

endmodule

// File: rtl/pwr_seq_top.sv
// Module: platform power-up sequencer top. It synchronizes the board
// inputs, runs the controller and registers the rail enables from the
// next level, so that each enable changes in the same cycle as the level.
// Assumes: RAIL_ORDER is a permutation; every timeout, STAB_CYCLES and
// OFF_GAP is at least 1 and fits TMR_W bits.
module pwr_seq_top #(
    parameter int unsigned N_RAILS                = 4,
    parameter int unsigned RAIL_ORDER   [N_RAILS] = '{3, 2, 1, 0},
    parameter int unsigned RAIL_TIMEOUT [N_RAILS] = '{2000, 2000, 2000, 2000},
    parameter int unsigned STAB_CYCLES            = 1000,
    parameter int unsigned OFF_GAP                = 50,
    parameter int unsigned TMR_W                  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_btn_i,
    input  logic [N_RAILS-1:0] rail_pg_i,
    input  logic               pll_lock_i,
    output logic [N_RAILS-1:0] rail_en_o,
    output logic               cpu_rst_n_o
);

    localparam int unsigned LVL_W  = $clog2(N_RAILS + 1);
    localparam int unsigned IDX_W  = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
    localparam int unsigned SYNC_W = N_RAILS + 2;

    logic [SYNC_W-1:0]  sync_q;
    logic               btn_s;
    logic               lock_s;
    logic [N_RAILS-1:0] pg_s;
    logic [LVL_W-1:0]   lvl_q, lvl_d;
    logic [N_RAILS-1:0] en_now, en_next;
    logic [IDX_W-1:0]   cur_rail;
    logic [TMR_W-1:0]   cur_last;
    logic [TMR_W-1:0]   tmr_cnt;
    logic               tmr_clr, tmr_inc;

    pwr_seq_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({pwr_btn_i, pll_lock_i, rail_pg_i}),
        .q_o   (sync_q)
    );
    assign btn_s  = sync_q[SYNC_W-1];
    assign lock_s = sync_q[SYNC_W-2];
    assign pg_s   = sync_q[N_RAILS-1:0];

    pwr_seq_timer #(.TMR_W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .inc_i (tmr_inc),
        .cnt_o (tmr_cnt)
    );

    pwr_seq_map #(.N_RAILS(N_RAILS), .RAIL_ORDER(RAIL_ORDER), .LVL_W(LVL_W)) u_map_now (
        .lvl_i (lvl_q),
        .en_o  (en_now)
    );

    pwr_seq_map #(.N_RAILS(N_RAILS), .RAIL_ORDER(RAIL_ORDER), .LVL_W(LVL_W)) u_map_next (
        .lvl_i (lvl_d),
        .en_o  (en_next)
    );

    pwr_seq_sel #(
        .N_RAILS(N_RAILS), .RAIL_ORDER(RAIL_ORDER), .RAIL_TIMEOUT(RAIL_TIMEOUT),
        .LVL_W(LVL_W), .IDX_W(IDX_W), .TMR_W(TMR_W)
    ) u_sel (
        .lvl_i      (lvl_q),
        .cur_rail_o (cur_rail),
        .cur_last_o (cur_last)
    );

    pwr_seq_fsm #(
        .N_RAILS(N_RAILS), .STAB_CYCLES(STAB_CYCLES), .OFF_GAP(OFF_GAP),
        .LVL_W(LVL_W), .IDX_W(IDX_W), .TMR_W(TMR_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .btn_i       (btn_s),
        .pg_i        (pg_s),
        .lock_i      (lock_s),
        .en_now_i    (en_now),
        .cur_rail_i  (cur_rail),
        .cur_last_i  (cur_last),
        .tmr_i       (tmr_cnt),
        .tmr_clr_o   (tmr_clr),
        .tmr_inc_o   (tmr_inc),
        .lvl_q_o     (lvl_q),
        .lvl_d_o     (lvl_d),
        .cpu_rst_n_o (cpu_rst_n_o)
    );

    // Glitch-free enable outputs for the external switches.
    always_ff @(posedge clk) begin
        if (!rst_n) rail_en_o <= '0;
        else        rail_en_o <= en_next;
    end

endmodule

// File: rtl/pwr_seq_chk.sv
// Module: property checker for the power-up sequencer, bound to the top.
// Assumes: pg_s / lock_s are the synchronized status seen by the controller.
module pwr_seq_chk #(
    parameter int unsigned N_RAILS     = 4,
    parameter int unsigned STAB_CYCLES = 1000,
    parameter int unsigned OFF_GAP     = 50
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_RAILS-1:0] rail_en,
    input logic               cpu_rst_n,
    input logic [N_RAILS-1:0] pg_s,
    input logic               lock_s
);

    logic [31:0] good_run_q;
    logic [15:0] rst_low_q;

    // Length of the current run of all-good, locked, all-on cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                            good_run_q <= '0;
        else if ((&pg_s) && lock_s && (&rail_en)) good_run_q <= good_run_q + 32'd1;
        else                                   good_run_q <= '0;
    end

    // Length of the current run of cycles with processor reset asserted.
    always_ff @(posedge clk) begin
        if (!rst_n || cpu_rst_n)     rst_low_q <= '0;
        else if (rst_low_q != '1)    rst_low_q <= rst_low_q + 16'd1;
    end

    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rail_en ^ $past(rail_en)) <= 1);

    a_r3_release_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> $past((&pg_s) && lock_s));

    a_r3_release_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> (good_run_q >= STAB_CYCLES));

    a_r3_running_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n |-> (&rail_en));

    a_r4_reset_before_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(rail_en) & ~rail_en)) |-> (!cpu_rst_n && (rst_low_q >= OFF_GAP)));

endmodule

bind pwr_seq_top pwr_seq_chk #(
    .N_RAILS(N_RAILS), .STAB_CYCLES(STAB_CYCLES), .OFF_GAP(OFF_GAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rail_en   (rail_en_o),
    .cpu_rst_n (cpu_rst_n_o),
    .pg_s      (pg_s),
    .lock_s    (lock_s)
);

// File: tb/pwr_seq_top_test.sv
`timescale 1ns/1ps
// Bench: board model (power-good follows each enable after a random delay,
// lock follows all-good), random and directed scenarios, and an edge monitor
// that checks order, spacing and reset timing from the requirements.
module pwr_seq_top_test;

    localparam int N = 4;
    localparam int unsigned ORD [N] = '{3, 2, 1, 0};
    localparam int unsigned TOV [N] = '{40, 40, 40, 40};
    localparam int STAB = 16;
    localparam int GAP  = 3;
    localparam int TO   = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         btn = 1'b0;
    logic [N-1:0] pg = '0;
    logic         pll_lock = 1'b0;
    logic [N-1:0] rail_en;
    logic         cpu_rst_n;

    int n_chk = 0;
    int n_fail = 0;

    int dly [N];
    int pcnt [N];
    logic [N-1:0] broken = '0;
    logic [N-1:0] drop = '0;
    logic lock_broken = 1'b0;
    logic lock_kill = 1'b0;
    int lcnt = 0;
    int lock_dly = 5;

    longint cyc = 0;
    logic [N-1:0] pe = '0;
    logic pr = 1'b0;
    int up_idx = 0;
    int good_cnt = 0;
    int low_cnt = 0;
    longint last_fall = -1;
    bit rst_seen = 1'b0;

    always #5 clk = ~clk;

    pwr_seq_top #(
        .N_RAILS(N), .RAIL_ORDER(ORD), .RAIL_TIMEOUT(TOV),
        .STAB_CYCLES(STAB), .OFF_GAP(GAP), .TMR_W(16)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_btn_i   (btn),
        .rail_pg_i   (pg),
        .pll_lock_i  (pll_lock),
        .rail_en_o   (rail_en),
        .cpu_rst_n_o (cpu_rst_n)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Highest switch-on step still enabled, as a rail number.
    function automatic int top_rail(input logic [N-1:0] en);
        int r = -1;
        for (int k = 0; k < N; k++) if (en[ORD[k]]) r = int'(ORD[k]);
        return r;
    endfunction

    // Board model: regulators and clock generator.
    always @(negedge clk) begin
        for (int r = 0; r < N; r++) begin
            if (!rail_en[r]) begin
                pcnt[r] = 0;
                pg[r] = 1'b0;
            end else if (broken[r] || drop[r]) begin
                pg[r] = 1'b0;
            end else if (pcnt[r] >= dly[r]) begin
                pg[r] = 1'b1;
            end else begin
                pcnt[r]++;
            end
        end
        if ((&pg) && !lock_broken && !lock_kill) begin
            if (lcnt >= lock_dly) pll_lock = 1'b1;
            else lcnt++;
        end else begin
            lcnt = 0;
            pll_lock = 1'b0;
        end
    end

    // Edge monitor, sampled after each rising edge.
    always @(posedge clk) begin
        #2;
        cyc++;
        if (rst_n) begin
            if (rail_en != pe) begin
                check($countones(rail_en ^ pe) == 1, "R8", "enables changed together",
                      $countones(rail_en ^ pe), 1);
                if (pe == '0) up_idx = 0;
                for (int r = 0; r < N; r++) begin
                    if (rail_en[r] && !pe[r]) begin
                        if (up_idx < N) begin
                            check(r == int'(ORD[up_idx]), "R1", "rail enabled at step",
                                  r, ORD[up_idx]);
                            if (up_idx > 0)
                                check(pg[ORD[up_idx-1]] == 1'b1, "R1", "previous rail good",
                                      pg[ORD[up_idx-1]], 1);
                        end
                        up_idx++;
                    end
                    if (!rail_en[r] && pe[r]) begin
                        check(!cpu_rst_n && low_cnt >= GAP, "R4", "reset-low cycles before drop",
                              low_cnt, GAP);
                        check(r == top_rail(pe), "R5", "rail dropped", r, top_rail(pe));
                        if (last_fall >= 0)
                            check(cyc - last_fall == GAP, "R5", "drop spacing",
                                  cyc - last_fall, GAP);
                        last_fall = cyc;
                    end
                end
                if (rail_en == '0) last_fall = -1;
            end
            if (cpu_rst_n && !pr) begin
                check((&pg) && pll_lock && good_cnt >= STAB && good_cnt <= STAB + 6,
                      "R3", "stable cycles before release", good_cnt, STAB);
                rst_seen = 1'b1;
            end
        end
        good_cnt = ((&pg) && pll_lock) ? good_cnt + 1 : 0;
        low_cnt  = cpu_rst_n ? 0 : low_cnt + 1;
        pe = rail_en;
        pr = cpu_rst_n;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rand_delays();
        for (int r = 0; r < N; r++) dly[r] = $urandom_range(20, 2);
        lock_dly = $urandom_range(8, 1);
    endtask

    task automatic power_up(output bit ok);
        int g = 0;
        btn = 1'b1;
        while (!cpu_rst_n && g < 3000) begin
            @(negedge clk);
            g++;
        end
        ok = cpu_rst_n;
    endtask

    task automatic wait_off(output bit ok);
        int g = 0;
        while (rail_en != '0 && g < 1000) begin
            @(negedge clk);
            g++;
        end
        ok = (rail_en == '0);
    endtask

    initial begin
        bit ok;
        int r;
        longint t0;
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin
            dly[i] = 5;
            pcnt[i] = 0;
        end

        tick(5);
        check(rail_en == '0, "R7", "enables in reset", rail_en, 0);
        check(cpu_rst_n == 1'b0, "R7", "processor reset in reset", cpu_rst_n, 0);
        rst_n = 1'b1;
        tick(40);
        check(rail_en == '0, "R6", "enables without a press", rail_en, 0);
        check(cpu_rst_n == 1'b0, "R7", "reset without a press", cpu_rst_n, 0);

        // Random bring-up and button-release shutdown.
        for (int it = 0; it < 5; it++) begin
            rand_delays();
            power_up(ok);
            check(ok, "R3", "reset released after bring-up", ok, 1);
            check(rail_en == '1, "R1", "all rails on", rail_en, 15);
            tick($urandom_range(20, 5));
            check(cpu_rst_n == 1'b1, "R3", "reset held released", cpu_rst_n, 1);
            btn = 1'b0;
            wait_off(ok);
            check(ok, "R5", "rails off after release", rail_en, 0);
            check(cpu_rst_n == 1'b0, "R4", "reset after release", cpu_rst_n, 0);
            tick(5);
        end

        // Power-good loss while running, button held.
        rand_delays();
        power_up(ok);
        r = $urandom_range(N - 1, 0);
        drop[r] = 1'b1;
        wait_off(ok);
        check(ok, "R4", "shutdown on power-good loss", rail_en, 0);
        check(cpu_rst_n == 1'b0, "R4", "reset after power-good loss", cpu_rst_n, 0);
        drop = '0;
        tick(60);
        check(rail_en == '0, "R6", "no restart with button held", rail_en, 0);
        btn = 1'b0;
        tick(5);

        // Timeout faults on random rails.
        for (int it = 0; it < 2; it++) begin
            int g = 0;
            rand_delays();
            r = $urandom_range(N - 1, 0);
            broken[r] = 1'b1;
            rst_seen = 1'b0;
            btn = 1'b1;
            while (!rail_en[r] && g < 2000) begin
                @(posedge clk); #2; g++;
            end
            t0 = cyc;
            g = 0;
            while (rail_en[r] && g < 2000) begin
                @(posedge clk); #2; g++;
            end
            check(cyc - t0 >= TO && cyc - t0 <= TO + GAP + 3, "R2",
                  "cycles from enable to fault drop", cyc - t0, TO + GAP);
            wait_off(ok);
            check(ok && !rst_seen, "R2", "fault kept reset and cleared rails", rst_seen, 0);
            tick(60);
            check(rail_en == '0, "R6", "no restart after fault", rail_en, 0);
            btn = 1'b0;
            broken = '0;
            tick(5);
        end

        // Lock never arrives.
        rand_delays();
        lock_broken = 1'b1;
        btn = 1'b1;
        tick(300);
        check(rail_en == '1 && !cpu_rst_n, "R3", "no release without lock",
              cpu_rst_n, 0);
        btn = 1'b0;
        wait_off(ok);
        check(ok, "R5", "off after lock wait", rail_en, 0);
        lock_broken = 1'b0;
        tick(5);

        // Lock lost while running.
        rand_delays();
        power_up(ok);
        lock_kill = 1'b1;
        tick(6);
        check(cpu_rst_n == 1'b0, "R4", "reset on lock loss", cpu_rst_n, 0);
        btn = 1'b0;
        wait_off(ok);
        check(ok, "R5", "off after lock loss", rail_en, 0);
        lock_kill = 1'b0;
        tick(5);

        // Button released part-way through the ramp.
        for (int i = 0; i < N; i++) dly[i] = 30;
        btn = 1'b1;
        begin
            int g = 0;
            while ($countones(rail_en) < 2 && g < 1000) begin
                @(negedge clk); g++;
            end
        end
        btn = 1'b0;
        wait_off(ok);
        check(ok && !cpu_rst_n, "R5", "partial ramp unwound", rail_en, 0);
        tick(5);

        // A fresh press starts again.
        rand_delays();
        power_up(ok);
        check(ok, "R6", "new press restarts", ok, 1);
        btn = 1'b0;
        wait_off(ok);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_500_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule